// File: doc/BRIEF.md
# Dual-Clock Byte-Masked Shared Memory with Two Bus Slave Ports

The block is a shared word memory reached through two independent slave ports that follow the Wishbone classic single-transfer handshake. Each port has its own clock and its own active-low reset. The two clocks may be unrelated. Either port can read or write any word of the array, and a word that one side stores can be read back through the other side.

Writes are masked per byte lane. Only the lanes whose select bit is high change, so an agent can perform partial or unaligned stores by splitting them into per-word writes with the matching lanes enabled. Each accepted request gets one registered acknowledge. Read data is presented in the same cycle as that acknowledge.

Top module: `dpram_bus_dual`

## Requirements
- R1: While a port's reset is low, its acknowledge is low. Releasing or pulsing either reset leaves the stored words unchanged.
- R2: A port accepts a request on a rising clock edge where cyc and stb are both high and acknowledge is low. Acknowledge rises on that edge and lasts exactly one cycle. A request held high is therefore acknowledged every second cycle.
- R3: With only one of cyc or stb high, the port gives no acknowledge and a pending write has no effect on memory.
- R4: Read data on a port equals the addressed word in the cycle acknowledge is high for a read. It then holds until that port's next read is accepted; writes and idle cycles do not change it.
- R5: A write changes only the byte lanes whose select bit is high. Bit l of sel covers data bits 8l+7..8l. A write with sel = 0 changes nothing.
- R6: The word index is address bits [IDX_W+1:2] (default bits 9..2). The two low byte-offset bits and all address bits above the index are ignored.
- R7: A word written through port A reads back through port B, and the reverse. For each byte, the most recent completed write from either port is returned.
- R8: Both ports may run transactions in the same cycles to different words without affecting each other's results.
- R9: A store of 1 to 7 bytes at any byte offset 0 to 3, issued as per-word masked writes, reads back exactly. The bytes around it keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a_i | input | 1 | Port A clock |
| rst_a_ni | input | 1 | Port A asynchronous reset, active low |
| adr_a_i | input | ADDR_W | Port A byte address |
| dat_a_i | input | DATA_W | Port A write data |
| dat_a_o | output | DATA_W | Port A read data |
| we_a_i | input | 1 | Port A write enable |
| sel_a_i | input | DATA_W/8 | Port A byte-lane selects |
| stb_a_i | input | 1 | Port A strobe |
| cyc_a_i | input | 1 | Port A bus cycle |
| ack_a_o | output | 1 | Port A acknowledge |
| clk_b_i | input | 1 | Port B clock |
| rst_b_ni | input | 1 | Port B asynchronous reset, active low |
| adr_b_i | input | ADDR_W | Port B byte address |
| dat_b_i | input | DATA_W | Port B write data |
| dat_b_o | output | DATA_W | Port B read data |
| we_b_i | input | 1 | Port B write enable |
| sel_b_i | input | DATA_W/8 | Port B byte-lane selects |
| stb_b_i | input | 1 | Port B strobe |
| cyc_b_i | input | 1 | Port B bus cycle |
| ack_b_o | output | 1 | Port B acknowledge |

## Verification
The stimulus includes full-word writes that are later overlaid by sparse lane masks and by a zero mask. These separate true per-lane gating from whole-word or inverted masking. A sweep of 1- to 7-byte stores at every start offset, each written on A and read on B over zeroed neighbour words, exposes lane or word-index errors and spill into adjacent bytes. Concurrent traffic on both clocks, a held request and half-asserted handshakes test the cross-port bank selection, the single-cycle acknowledge and the request qualification. Addresses with junk in the high and offset bits show whether the index is taken from the right field.

// File: rtl/dpram_pkg.sv
package dpram_pkg;
  localparam int unsigned LANE_W = 8;

  function automatic int unsigned lanes_of(int unsigned data_w);
    return data_w / LANE_W;
  endfunction
endpackage

// File: rtl/dpram_port_ctrl.sv
module dpram_port_ctrl #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned IDX_W  = 8,
  parameter int unsigned OFS_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cyc_i,
  input  logic              stb_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] adr_i,
  output logic              ack_o,
  output logic              wr_o,
  output logic              rd_o,
  output logic [IDX_W-1:0]  idx_o
);
  logic ack_q;
  logic req;
  logic unused_adr;

  // no new accept while the previous ack is out; nothing reaches the array in reset
  assign req = rst_ni & cyc_i & stb_i & ~ack_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ack_q <= 1'b0;
    else         ack_q <= req;
  end

  assign ack_o      = ack_q;
  assign wr_o       = req & we_i;
  assign rd_o       = req & ~we_i;
  assign idx_o      = adr_i[OFS_W +: IDX_W];
  assign unused_adr = ^adr_i;
endmodule

// File: rtl/dpram_lane.sv
// One byte lane. Each port owns a bank and a toggle per word; toggle
// equality tells the reader which bank holds the newest byte.
module dpram_lane #(
  parameter int unsigned IDX_W  = 8,
  parameter int unsigned LANE_W = 8
) (
  input  logic              clk_a_i,
  input  logic              wr_a_i,
  input  logic              rd_a_i,
  input  logic [IDX_W-1:0]  idx_a_i,
  input  logic [LANE_W-1:0] din_a_i,
  output logic [LANE_W-1:0] dout_a_o,
  input  logic              clk_b_i,
  input  logic              wr_b_i,
  input  logic              rd_b_i,
  input  logic [IDX_W-1:0]  idx_b_i,
  input  logic [LANE_W-1:0] din_b_i,
  output logic [LANE_W-1:0] dout_b_o
);
  localparam int unsigned DEPTH = 1 << IDX_W;

  logic [LANE_W-1:0] bank_a [DEPTH];
  logic [LANE_W-1:0] bank_b [DEPTH];
  logic [DEPTH-1:0]  tog_a;
  logic [DEPTH-1:0]  tog_b;

  always_ff @(posedge clk_a_i) begin
    if (wr_a_i) begin
      bank_a[idx_a_i] <= din_a_i;
      tog_a[idx_a_i]  <= tog_b[idx_a_i];
    end
    if (rd_a_i)
      dout_a_o <= (tog_a[idx_a_i] == tog_b[idx_a_i]) ? bank_a[idx_a_i] : bank_b[idx_a_i];
  end

  always_ff @(posedge clk_b_i) begin
    if (wr_b_i) begin
      bank_b[idx_b_i] <= din_b_i;
      tog_b[idx_b_i]  <= ~tog_a[idx_b_i];
    end
    if (rd_b_i)
      dout_b_o <= (tog_a[idx_b_i] == tog_b[idx_b_i]) ? bank_a[idx_b_i] : bank_b[idx_b_i];
  end
endmodule

// File: rtl/dpram_bus_dual.sv
module dpram_bus_dual #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned IDX_W  = 8
) (
  input  logic                                  clk_a_i,
  input  logic                                  rst_a_ni,
  input  logic [ADDR_W-1:0]                     adr_a_i,
  input  logic [DATA_W-1:0]                     dat_a_i,
  output logic [DATA_W-1:0]                     dat_a_o,
  input  logic                                  we_a_i,
  input  logic [dpram_pkg::lanes_of(DATA_W)-1:0] sel_a_i,
  input  logic                                  stb_a_i,
  input  logic                                  cyc_a_i,
  output logic                                  ack_a_o,
  input  logic                                  clk_b_i,
  input  logic                                  rst_b_ni,
  input  logic [ADDR_W-1:0]                     adr_b_i,
  input  logic [DATA_W-1:0]                     dat_b_i,
  output logic [DATA_W-1:0]                     dat_b_o,
  input  logic                                  we_b_i,
  input  logic [dpram_pkg::lanes_of(DATA_W)-1:0] sel_b_i,
  input  logic                                  stb_b_i,
  input  logic                                  cyc_b_i,
  output logic                                  ack_b_o
);
  localparam int unsigned LANE_W = dpram_pkg::LANE_W;
  localparam int unsigned SEL_W  = dpram_pkg::lanes_of(DATA_W);
  localparam int unsigned OFS_W  = $clog2(SEL_W);

  logic             wr_a, rd_a, wr_b, rd_b;
  logic [IDX_W-1:0] idx_a, idx_b;

  dpram_port_ctrl #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFS_W(OFS_W)) u_ctrl_a (
    .clk_i(clk_a_i), .rst_ni(rst_a_ni), .cyc_i(cyc_a_i), .stb_i(stb_a_i),
    .we_i(we_a_i), .adr_i(adr_a_i), .ack_o(ack_a_o), .wr_o(wr_a), .rd_o(rd_a),
    .idx_o(idx_a)
  );

  dpram_port_ctrl #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFS_W(OFS_W)) u_ctrl_b (
    .clk_i(clk_b_i), .rst_ni(rst_b_ni), .cyc_i(cyc_b_i), .stb_i(stb_b_i),
    .we_i(we_b_i), .adr_i(adr_b_i), .ack_o(ack_b_o), .wr_o(wr_b), .rd_o(rd_b),
    .idx_o(idx_b)
  );

  for (genvar l = 0; l < SEL_W; l++) begin : g_lane
    dpram_lane #(.IDX_W(IDX_W), .LANE_W(LANE_W)) u_lane (
      .clk_a_i (clk_a_i),
      .wr_a_i  (wr_a & sel_a_i[l]),
      .rd_a_i  (rd_a),
      .idx_a_i (idx_a),
      .din_a_i (dat_a_i[l*LANE_W +: LANE_W]),
      .dout_a_o(dat_a_o[l*LANE_W +: LANE_W]),
      .clk_b_i (clk_b_i),
      .wr_b_i  (wr_b & sel_b_i[l]),
      .rd_b_i  (rd_b),
      .idx_b_i (idx_b),
      .din_b_i (dat_b_i[l*LANE_W +: LANE_W]),
      .dout_b_o(dat_b_o[l*LANE_W +: LANE_W])
    );
  end
endmodule

// File: rtl/dpram_bus_dual_chk.sv
module dpram_bus_dual_chk #(
  parameter int unsigned DATA_W = 32
) (
  input logic              clk_a_i,
  input logic              rst_a_ni,
  input logic              cyc_a_i,
  input logic              stb_a_i,
  input logic              we_a_i,
  input logic              ack_a_o,
  input logic [DATA_W-1:0] dat_a_o,
  input logic              clk_b_i,
  input logic              rst_b_ni,
  input logic              cyc_b_i,
  input logic              stb_b_i,
  input logic              we_b_i,
  input logic              ack_b_o,
  input logic [DATA_W-1:0] dat_b_o
);
  a_r1_ack_low_in_reset_a: assert property (@(posedge clk_a_i) !rst_a_ni |-> !ack_a_o);
  a_r1_ack_low_in_reset_b: assert property (@(posedge clk_b_i) !rst_b_ni |-> !ack_b_o);

  a_r2_ack_single_a: assert property (@(posedge clk_a_i) disable iff (!rst_a_ni)
    ack_a_o |=> !ack_a_o);
  a_r2_ack_single_b: assert property (@(posedge clk_b_i) disable iff (!rst_b_ni)
    ack_b_o |=> !ack_b_o);

  a_r3_ack_needs_req_a: assert property (@(posedge clk_a_i) disable iff (!rst_a_ni)
    ack_a_o |-> $past(cyc_a_i && stb_a_i));
  a_r3_ack_needs_req_b: assert property (@(posedge clk_b_i) disable iff (!rst_b_ni)
    ack_b_o |-> $past(cyc_b_i && stb_b_i));

  a_r4_rdata_hold_a: assert property (@(posedge clk_a_i) disable iff (!rst_a_ni)
    !$past(cyc_a_i && stb_a_i && !we_a_i && !ack_a_o) |-> $stable(dat_a_o));
  a_r4_rdata_hold_b: assert property (@(posedge clk_b_i) disable iff (!rst_b_ni)
    !$past(cyc_b_i && stb_b_i && !we_b_i && !ack_b_o) |-> $stable(dat_b_o));
endmodule

bind dpram_bus_dual dpram_bus_dual_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_a_i(clk_a_i), .rst_a_ni(rst_a_ni), .cyc_a_i(cyc_a_i), .stb_a_i(stb_a_i),
  .we_a_i(we_a_i), .ack_a_o(ack_a_o), .dat_a_o(dat_a_o),
  .clk_b_i(clk_b_i), .rst_b_ni(rst_b_ni), .cyc_b_i(cyc_b_i), .stb_b_i(stb_b_i),
  .we_b_i(we_b_i), .ack_b_o(ack_b_o), .dat_b_o(dat_b_o)
);

// File: tb/dpram_bus_dual_tb_top.sv
module dpram_bus_dual_tb_top;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int DW = 32;
  localparam int AW = 32;
  localparam int IW = 8;
  localparam int SW = 4;
  localparam int NB = (1 << IW) * SW;

  typedef struct {
    logic [DW-1:0] d;
    string         t;
  } exp_t;

  logic          clk_a = 1'b0, clk_b = 1'b0;
  logic          rst_a_n = 1'b0, rst_b_n = 1'b0;
  logic [AW-1:0] adr_a = '0, adr_b = '0;
  logic [DW-1:0] wdat_a = '0, wdat_b = '0;
  logic [DW-1:0] rdat_a, rdat_b;
  logic          we_a = 1'b0, we_b = 1'b0;
  logic [SW-1:0] sel_a = '0, sel_b = '0;
  logic          stb_a = 1'b0, stb_b = 1'b0, cyc_a = 1'b0, cyc_b = 1'b0;
  logic          ack_a, ack_b;

  always #5 clk_a = ~clk_a;   // 100 MHz
  always #6 clk_b = ~clk_b;   // unrelated second domain

  dpram_bus_dual #(.DATA_W(DW), .ADDR_W(AW), .IDX_W(IW)) dut_i (
    .clk_a_i(clk_a), .rst_a_ni(rst_a_n), .adr_a_i(adr_a), .dat_a_i(wdat_a),
    .dat_a_o(rdat_a), .we_a_i(we_a), .sel_a_i(sel_a), .stb_a_i(stb_a),
    .cyc_a_i(cyc_a), .ack_a_o(ack_a),
    .clk_b_i(clk_b), .rst_b_ni(rst_b_n), .adr_b_i(adr_b), .dat_b_i(wdat_b),
    .dat_b_o(rdat_b), .we_b_i(we_b), .sel_b_i(sel_b), .stb_b_i(stb_b),
    .cyc_b_i(cyc_b), .ack_b_o(ack_b)
  );

  int   n_vec = 0, n_bad = 0;
  bit   scb_on = 1'b1;
  bit   done = 1'b0;
  exp_t q_a[$], q_b[$];
  logic [7:0] mdl [NB];

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // R6: word index from address bits [IW+1:2]
  function automatic int idx_of(input logic [AW-1:0] adr);
    return int'(adr[2 +: IW]);
  endfunction

  function automatic logic [DW-1:0] mdl_word(input int idx);
    logic [DW-1:0] w;
    for (int b = 0; b < SW; b++) w[8*b +: 8] = mdl[idx*SW + b];
    return w;
  endfunction

  task automatic mdl_write(input logic [AW-1:0] adr, input logic [DW-1:0] d, input logic [SW-1:0] sel);
    for (int b = 0; b < SW; b++)
      if (sel[b]) mdl[idx_of(adr)*SW + b] = d[8*b +: 8];
  endtask

  // monitors: compare read data on every read acknowledge
  always @(negedge clk_a) begin
    if (scb_on && ack_a && !we_a) begin
      if (q_a.size() == 0) chk("R4 unexpected ack A", 32'd1, 32'd0);
      else begin
        exp_t e;
        e = q_a.pop_front();
        chk(e.t, rdat_a, e.d);
      end
    end
  end

  always @(negedge clk_b) begin
    if (scb_on && ack_b && !we_b) begin
      if (q_b.size() == 0) chk("R4 unexpected ack B", 32'd1, 32'd0);
      else begin
        exp_t e;
        e = q_b.pop_front();
        chk(e.t, rdat_b, e.d);
      end
    end
  end

  task automatic xfer_a(input bit w, input logic [AW-1:0] adr, input logic [DW-1:0] d, input logic [SW-1:0] sel);
    @(posedge clk_a); #1;
    cyc_a = 1'b1; stb_a = 1'b1; we_a = w; adr_a = adr; wdat_a = d; sel_a = sel;
    @(negedge clk_a);
    while (!ack_a) @(negedge clk_a);
    @(posedge clk_a); #1;
    cyc_a = 1'b0; stb_a = 1'b0; we_a = 1'b0;
  endtask

  task automatic xfer_b(input bit w, input logic [AW-1:0] adr, input logic [DW-1:0] d, input logic [SW-1:0] sel);
    @(posedge clk_b); #1;
    cyc_b = 1'b1; stb_b = 1'b1; we_b = w; adr_b = adr; wdat_b = d; sel_b = sel;
    @(negedge clk_b);
    while (!ack_b) @(negedge clk_b);
    @(posedge clk_b); #1;
    cyc_b = 1'b0; stb_b = 1'b0; we_b = 1'b0;
  endtask

  task automatic wr_a(input logic [AW-1:0] adr, input logic [DW-1:0] d, input logic [SW-1:0] sel);
    mdl_write(adr, d, sel);
    xfer_a(1'b1, adr, d, sel);
  endtask

  task automatic wr_b(input logic [AW-1:0] adr, input logic [DW-1:0] d, input logic [SW-1:0] sel);
    mdl_write(adr, d, sel);
    xfer_b(1'b1, adr, d, sel);
  endtask

  task automatic rd_a(input logic [AW-1:0] adr, input string tag);
    exp_t e;
    e.d = mdl_word(idx_of(adr));
    e.t = tag;
    q_a.push_back(e);
    xfer_a(1'b0, adr, '0, '0);
  endtask

  task automatic rd_b(input logic [AW-1:0] adr, input string tag);
    exp_t e;
    e.d = mdl_word(idx_of(adr));
    e.t = tag;
    q_b.push_back(e);
    xfer_b(1'b0, adr, '0, '0);
  endtask

  // R9: store len bytes of 0x11,0x22,... from byte address start, split into masked word writes
  task automatic store_bytes_a(input int start, input int len);
    for (int w = start / SW; w <= (start + len - 1) / SW; w++) begin
      logic [DW-1:0] d;
      logic [SW-1:0] s;
      d = '0;
      s = '0;
      for (int b = 0; b < SW; b++) begin
        int k;
        k = w * SW + b - start;
        if (k >= 0 && k < len) begin
          s[b] = 1'b1;
          d[8*b +: 8] = 8'(8'h11 * (k + 1));
        end
      end
      wr_a(AW'(w * SW), d, s);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    n_vec++;
    n_bad++;
    $display("FAIL watchdog R2 handshake hang act=%h exp=%h", 32'd0, 32'd1);
    finish_run();
  end

  initial begin
    for (int i = 0; i < NB; i++) mdl[i] = 8'h00;

    // R1: acknowledge low during reset
    repeat (3) @(negedge clk_a);
    chk("R1 ack A in reset", {31'd0, ack_a}, 32'd0);
    chk("R1 ack B in reset", {31'd0, ack_b}, 32'd0);
    @(posedge clk_a); #1; rst_a_n = 1'b1;
    @(posedge clk_b); #1; rst_b_n = 1'b1;
    repeat (2) @(negedge clk_a);
    chk("R1 ack A after reset", {31'd0, ack_a}, 32'd0);

    // clear the working region so every read has a defined expectation
    for (int w = 0; w < 256; w++) wr_a(AW'(w * SW), 32'h0, 4'hF);

    // R5: lane masking, read on both ports
    wr_a(32'h40, 32'hDEADBEEF, 4'hF);
    wr_a(32'h40, 32'h11223344, 4'b0101);
    rd_a(32'h40, "R5 mask 0101 on A");
    rd_b(32'h40, "R5 mask 0101 via B");
    wr_b(32'h40, 32'hFFFFFFFF, 4'b0000);
    rd_a(32'h40, "R5 zero mask no change");
    wr_b(32'h40, 32'hA5A5A5A5, 4'b1000);
    rd_b(32'h40, "R5 top lane only");

    // R7: cross-port read back both directions
    wr_a(32'h50, 32'h0BADF00D, 4'hF);
    rd_b(32'h50, "R7 A to B");
    wr_b(32'h54, 32'hFEEDC0DE, 4'hF);
    rd_a(32'h54, "R7 B to A");
    wr_b(32'h50, 32'h00C0FFEE, 4'b0011);
    rd_a(32'h50, "R7 newest byte wins mixed");

    // R6: high and offset address bits ignored
    wr_a(32'hFFFF_0000 | (32'h41 << 2) | 32'h3, 32'hCAFEF00D, 4'hF);
    rd_b(32'h41 << 2, "R6 high/offset bits ignored");
    rd_a(32'h8000_0000 | (32'h41 << 2) | 32'h1, "R6 aliased read");

    // R9: unaligned 1..7 byte stores, written on A, read on B with neighbours
    for (int len = 1; len < 8; len++)
      for (int off = 0; off < 4; off++) begin
        int base;
        base = (32 + (len * 4 + off) * 4) * SW;
        store_bytes_a(base + off, len);
        for (int w = 0; w < 4; w++) rd_b(AW'(base + w * SW), "R9 unaligned store");
      end

    // R8/R7: both ports busy at once on disjoint words, then cross reads
    fork
      for (int i = 0; i < 16; i++) wr_a(AW'((160 + i) * SW), 32'hA0000000 | i, 4'hF);
      for (int i = 0; i < 16; i++) wr_b(AW'((180 + i) * SW), 32'hB0000000 | i, 4'hF);
    join
    fork
      for (int i = 0; i < 16; i++) rd_a(AW'((180 + i) * SW), "R8 concurrent B data on A");
      for (int i = 0; i < 16; i++) rd_b(AW'((160 + i) * SW), "R8 concurrent A data on B");
    join

    // R4: read data held across writes and idle cycles
    rd_a(32'h50, "R4 read before hold");
    wr_a(32'h60, 32'h12345678, 4'hF);
    repeat (3) @(negedge clk_a);
    chk("R4 hold after write and idle", rdat_a, mdl_word(idx_of(32'h50)));

    // R3: half handshakes give no ack and no write
    begin
      int acks;
      acks = 0;
      @(posedge clk_a); #1;
      stb_a = 1'b1; cyc_a = 1'b0; we_a = 1'b1; adr_a = 32'h60; wdat_a = 32'hFFFFFFFF; sel_a = 4'hF;
      repeat (4) begin @(negedge clk_a); if (ack_a) acks++; end
      @(posedge clk_a); #1; stb_a = 1'b0; cyc_a = 1'b1;
      repeat (4) begin @(negedge clk_a); if (ack_a) acks++; end
      @(posedge clk_a); #1; cyc_a = 1'b0; we_a = 1'b0;
      chk("R3 no ack on half handshake", 32'(acks), 32'd0);
    end
    rd_a(32'h60, "R3 memory untouched");

    // R2: held request acknowledged every other cycle
    scb_on = 1'b0;
    begin
      logic [5:0] pat;
      pat = '0;
      @(posedge clk_a); #1;
      cyc_a = 1'b1; stb_a = 1'b1; we_a = 1'b0; adr_a = 32'h60;
      for (int c = 0; c < 6; c++) begin @(negedge clk_a); pat = {pat[4:0], ack_a}; end
      @(posedge clk_a); #1; cyc_a = 1'b0; stb_a = 1'b0;
      chk("R2 ack pattern held req", 32'(pat), 32'b010101);
    end
    repeat (2) @(posedge clk_a);
    scb_on = 1'b1;

    // R1: reset pulse keeps memory
    @(posedge clk_a); #1; rst_a_n = 1'b0;
    @(posedge clk_b); #1; rst_b_n = 1'b0;
    repeat (2) @(negedge clk_b);
    chk("R1 ack B in mid reset", {31'd0, ack_b}, 32'd0);
    @(posedge clk_a); #1; rst_a_n = 1'b1;
    @(posedge clk_b); #1; rst_b_n = 1'b1;
    rd_b(32'h40, "R1 memory kept over reset");
    rd_a(32'h54, "R1 memory kept over reset A");

    repeat (4) @(posedge clk_b);
    chk("R4 no read left pending A", 32'(q_a.size()), 32'd0);
    chk("R4 no read left pending B", 32'(q_b.size()), 32'd0);
    finish_run();
  end
endmodule